// File: doc/BRIEF.md
# Serial Display Lane High-Speed Entry Sequencer

This block steps one serial display data lane, together with its companion clock lane, through the move from the low-power idle state into high-speed transmission, through the payload burst, and back to low power. It runs entirely in the byte-clock domain. One byte clock equals eight bit intervals, so every phase length is a count of byte clocks. Software computes each count by dividing the absolute time the phase needs by eight bit intervals. The usual counts are 16 for the low-power step, 3/5/5/5 for data prepare/zero/trail/exit, and 10/12/10/3/14 for clock prepare/zero/post/trail/exit. For the data lane, prepare plus zero must together cover at least 145 ns plus ten bit intervals.

A producer holds `tx_req` high with a byte on `tx_data`. The byte is taken on every cycle where `tx_req` and `tx_ready` are both high. The block reports each lane's line state as a 3-bit code and gives the byte for the serialiser. The clock lane always reaches high-speed state before the data lane leaves LP-11, and it stays high-speed for a post interval after the data burst ends.

Top module: `dphy_hs_seq`

## Requirements
- R1: After reset, `dat_state` and `clk_state` both read LP-11 (code 0), `tx_ready` is 0 and `dat_byte` is 0x00. Line-state codes are: LP-11=0, LP-01=1, LP-00=2, HS-0=3, HS-data=4, HS-trail=5.
- R2: The data lane leaves LP-11 and then shows LP-01 for the LPX count, LP-00 for the data prepare count and HS-0 for the data zero count, in that order.
- R3: The cycle after HS-0 is a single HS-data cycle carrying byte 0xB8. `tx_ready` is high only in HS-data cycles. A byte accepted on a cycle appears on `dat_byte` on the next cycle, so an N-byte burst shows N+1 HS-data cycles with the payload in order.
- R4: The first HS-data cycle with `tx_req` low ends the burst. The lane then shows HS-trail for the data trail count. During trail every bit of `dat_byte` equals the inverse of bit 7 (the last serialised bit) of the final byte sent.
- R5: After trail the data lane holds LP-11 for at least the data exit count before it starts a new entry.
- R6: The clock lane entry is LP-01 for the LPX count, then LP-00 for the clock prepare count, then HS-0 for the clock zero count, then HS-data (clock running).
- R7: Whenever the data lane is in LP-01, the clock lane is in HS-data.
- R8: After the data trail's last cycle, the clock lane stays in HS-data for the clock post count and then in HS-trail for the clock trail count. It then holds LP-11 for the clock exit count plus one cycle in which a pending request is sampled, and after that it starts LP-01.
- R9: A phase count of zero lasts one byte clock, so no phase is ever skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_req | input | 1 | Burst request and byte-valid |
| tx_data | input | 8 | Payload byte |
| tx_ready | output | 1 | Byte taken when high with tx_req |
| cfg_lpx | input | CNT_W | Low-power step count |
| cfg_hs_prep | input | CNT_W | Data prepare count |
| cfg_hs_zero | input | CNT_W | Data zero count |
| cfg_hs_trail | input | CNT_W | Data trail count |
| cfg_hs_exit | input | CNT_W | Data exit count |
| cfg_ck_prep | input | CNT_W | Clock prepare count |
| cfg_ck_zero | input | CNT_W | Clock zero count |
| cfg_ck_post | input | CNT_W | Clock post count |
| cfg_ck_trail | input | CNT_W | Clock trail count |
| cfg_ck_exit | input | CNT_W | Clock exit count |
| dat_state | output | 3 | Data lane line-state code |
| dat_byte | output | 8 | Byte for the serialiser |
| clk_state | output | 3 | Clock lane line-state code |

## Verification
The bench measures every phase run length against the counts. An off-by-one counter load would stretch or shorten each phase by one byte clock. The bench sends a final byte with bit 7 set and another with bit 7 clear; a design that inverts the wrong bit, or never inverts it, shows a trail byte of the wrong polarity. With all counts at zero, a design that skipped phases would drop LP-01, LP-00 or HS-0 entirely. In the back-to-back run, a design that let the data lane start before the clock lane was running again, or that shortened the clock post or exit interval, would show a wrong clock run length or a data entry under a non-running clock.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

    typedef enum logic [2:0] {
        LS_LP11  = 3'd0,
        LS_LP01  = 3'd1,
        LS_LP00  = 3'd2,
        LS_HS0   = 3'd3,
        LS_HSD   = 3'd4,
        LS_HST   = 3'd5
    } line_t;

    typedef enum logic [2:0] {
        D_IDLE, D_LPX, D_PREP, D_ZERO, D_SYNC, D_PAY, D_TRAIL, D_EXIT
    } dat_st_t;

    typedef enum logic [2:0] {
        C_IDLE, C_LPX, C_PREP, C_ZERO, C_RUN, C_POST, C_TRAIL, C_EXIT
    } clk_st_t;

    localparam logic [7:0] SYNC_BYTE = 8'hB8;

endpackage

// File: rtl/dphy_clk_lane.sv
module dphy_clk_lane
    import dphy_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             data_trail_done,
    input  logic [CNT_W-1:0] lpx_cnt,
    input  logic [CNT_W-1:0] prep_cnt,
    input  logic [CNT_W-1:0] zero_cnt,
    input  logic [CNT_W-1:0] post_cnt,
    input  logic [CNT_W-1:0] trail_cnt,
    input  logic [CNT_W-1:0] exit_cnt,
    output logic             lane_running,
    output line_t            line_st
);

    typedef struct packed {
        clk_st_t          st;
        logic [CNT_W-1:0] cnt;
    } creg_t;

    creg_t r_q, r_d;

    // phase of c cycles: load c-1, zero treated as one cycle
    function automatic logic [CNT_W-1:0] load_of(input logic [CNT_W-1:0] c);
        return (c == '0) ? '0 : c - 1'b1;
    endfunction

    logic phase_end;
    assign phase_end = (r_q.cnt == '0);

    always_comb begin
        r_d = r_q;
        if (!phase_end) r_d.cnt = r_q.cnt - 1'b1;
        case (r_q.st)
            C_IDLE:  if (start_req) begin
                         r_d.st  = C_LPX;
                         r_d.cnt = load_of(lpx_cnt);
                     end
            C_LPX:   if (phase_end) begin
                         r_d.st  = C_PREP;
                         r_d.cnt = load_of(prep_cnt);
                     end
            C_PREP:  if (phase_end) begin
                         r_d.st  = C_ZERO;
                         r_d.cnt = load_of(zero_cnt);
                     end
            C_ZERO:  if (phase_end) begin
                         r_d.st  = C_RUN;
                         r_d.cnt = '0;
                     end
            C_RUN:   if (data_trail_done) begin
                         r_d.st  = C_POST;
                         r_d.cnt = load_of(post_cnt);
                     end
            C_POST:  if (phase_end) begin
                         r_d.st  = C_TRAIL;
                         r_d.cnt = load_of(trail_cnt);
                     end
            C_TRAIL: if (phase_end) begin
                         r_d.st  = C_EXIT;
                         r_d.cnt = load_of(exit_cnt);
                     end
            C_EXIT:  if (phase_end) begin
                         r_d.st  = C_IDLE;
                     end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= C_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.st)
            C_LPX:          line_st = LS_LP01;
            C_PREP:         line_st = LS_LP00;
            C_ZERO:         line_st = LS_HS0;
            C_RUN, C_POST:  line_st = LS_HSD;
            C_TRAIL:        line_st = LS_HST;
            default:        line_st = LS_LP11;
        endcase
    end

    assign lane_running = (r_q.st == C_RUN);

endmodule

// File: rtl/dphy_data_lane.sv
module dphy_data_lane
    import dphy_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_lane_running,
    input  logic             tx_req,
    input  logic [7:0]       tx_data,
    input  logic [CNT_W-1:0] lpx_cnt,
    input  logic [CNT_W-1:0] prep_cnt,
    input  logic [CNT_W-1:0] zero_cnt,
    input  logic [CNT_W-1:0] trail_cnt,
    input  logic [CNT_W-1:0] exit_cnt,
    output logic             tx_ready,
    output logic             trail_done,
    output line_t            line_st,
    output logic [7:0]       hs_byte
);

    typedef struct packed {
        dat_st_t          st;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       byt;
    } dreg_t;

    dreg_t r_q, r_d;

    function automatic logic [CNT_W-1:0] load_of(input logic [CNT_W-1:0] c);
        return (c == '0) ? '0 : c - 1'b1;
    endfunction

    logic phase_end;
    assign phase_end = (r_q.cnt == '0);

    always_comb begin
        r_d = r_q;
        if (!phase_end) r_d.cnt = r_q.cnt - 1'b1;
        case (r_q.st)
            D_IDLE:  if (tx_req && clk_lane_running) begin
                         r_d.st  = D_LPX;
                         r_d.cnt = load_of(lpx_cnt);
                     end
            D_LPX:   if (phase_end) begin
                         r_d.st  = D_PREP;
                         r_d.cnt = load_of(prep_cnt);
                     end
            D_PREP:  if (phase_end) begin
                         r_d.st  = D_ZERO;
                         r_d.cnt = load_of(zero_cnt);
                     end
            D_ZERO:  if (phase_end) begin
                         r_d.st  = D_SYNC;
                         r_d.byt = SYNC_BYTE;
                     end
            D_SYNC, D_PAY: begin
                         if (tx_req) begin
                             r_d.st  = D_PAY;
                             r_d.byt = tx_data;
                         end else begin
                             // hold the opposite of the last serialised bit (MSB)
                             r_d.st  = D_TRAIL;
                             r_d.cnt = load_of(trail_cnt);
                             r_d.byt = {8{~r_q.byt[7]}};
                         end
                     end
            D_TRAIL: if (phase_end) begin
                         r_d.st  = D_EXIT;
                         r_d.cnt = load_of(exit_cnt);
                         r_d.byt = '0;
                     end
            D_EXIT:  if (phase_end) begin
                         r_d.st  = D_IDLE;
                     end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= D_IDLE;
            r_q.cnt <= '0;
            r_q.byt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.st)
            D_LPX:          line_st = LS_LP01;
            D_PREP:         line_st = LS_LP00;
            D_ZERO:         line_st = LS_HS0;
            D_SYNC, D_PAY:  line_st = LS_HSD;
            D_TRAIL:        line_st = LS_HST;
            default:        line_st = LS_LP11;
        endcase
    end

    assign tx_ready   = (r_q.st == D_SYNC) || (r_q.st == D_PAY);
    assign trail_done = (r_q.st == D_TRAIL) && phase_end;
    assign hs_byte    = r_q.byt;

endmodule

// File: rtl/dphy_hs_seq.sv
module dphy_hs_seq
    import dphy_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_req,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    input  logic [CNT_W-1:0] cfg_lpx,
    input  logic [CNT_W-1:0] cfg_hs_prep,
    input  logic [CNT_W-1:0] cfg_hs_zero,
    input  logic [CNT_W-1:0] cfg_hs_trail,
    input  logic [CNT_W-1:0] cfg_hs_exit,
    input  logic [CNT_W-1:0] cfg_ck_prep,
    input  logic [CNT_W-1:0] cfg_ck_zero,
    input  logic [CNT_W-1:0] cfg_ck_post,
    input  logic [CNT_W-1:0] cfg_ck_trail,
    input  logic [CNT_W-1:0] cfg_ck_exit,
    output logic [2:0]       dat_state,
    output logic [7:0]       dat_byte,
    output logic [2:0]       clk_state
);

    logic  ck_running;
    logic  dat_trail_done;
    line_t ck_ls;
    line_t dat_ls;

    dphy_clk_lane #(.CNT_W(CNT_W)) u_clk_lane (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_req       (tx_req),
        .data_trail_done (dat_trail_done),
        .lpx_cnt         (cfg_lpx),
        .prep_cnt        (cfg_ck_prep),
        .zero_cnt        (cfg_ck_zero),
        .post_cnt        (cfg_ck_post),
        .trail_cnt       (cfg_ck_trail),
        .exit_cnt        (cfg_ck_exit),
        .lane_running    (ck_running),
        .line_st         (ck_ls)
    );

    dphy_data_lane #(.CNT_W(CNT_W)) u_data_lane (
        .clk              (clk),
        .rst_n            (rst_n),
        .clk_lane_running (ck_running),
        .tx_req           (tx_req),
        .tx_data          (tx_data),
        .lpx_cnt          (cfg_lpx),
        .prep_cnt         (cfg_hs_prep),
        .zero_cnt         (cfg_hs_zero),
        .trail_cnt        (cfg_hs_trail),
        .exit_cnt         (cfg_hs_exit),
        .tx_ready         (tx_ready),
        .trail_done       (dat_trail_done),
        .line_st          (dat_ls),
        .hs_byte          (dat_byte)
    );

    assign dat_state = dat_ls;
    assign clk_state = ck_ls;

endmodule

// File: rtl/dphy_hs_seq_chk.sv
module dphy_hs_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_ready,
    input logic [2:0] dat_state,
    input logic [7:0] dat_byte,
    input logic [2:0] clk_state
);

    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_state <= 3'd5) && (clk_state <= 3'd5));

    a_r2_zero_after_prep: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_state == 3'd3) |-> ($past(dat_state) == 3'd2 || $past(dat_state) == 3'd3));

    a_r3_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_state == 3'd4 && $past(dat_state) == 3'd3) |-> (dat_byte == 8'hB8));

    a_r3_ready_in_hs: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (dat_state == 3'd4));

    a_r4_trail_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_state == 3'd5 && $past(dat_state) == 3'd4) |-> (dat_byte == {8{~$past(dat_byte[7])}}));

    a_r7_clock_first: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_state == 3'd1) |-> (clk_state == 3'd4));

    a_r8_clk_trail_data_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_state == 3'd5) |-> (dat_state == 3'd0));

endmodule

bind dphy_hs_seq dphy_hs_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_ready  (tx_ready),
    .dat_state (dat_state),
    .dat_byte  (dat_byte),
    .clk_state (clk_state)
);

// File: tb/tb_dphy_hs_seq.sv
`timescale 1ns/1ps
module tb_dphy_hs_seq;

    localparam int CNT_W = 8;
    localparam int LOGN  = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_req = 1'b0;
    logic [7:0] tx_data = '0;
    logic tx_ready;
    logic [CNT_W-1:0] c_lpx, c_hp, c_hz, c_ht, c_hx, c_cp, c_cz, c_cpo, c_ct, c_cx;
    logic [2:0] dat_state, clk_state;
    logic [7:0] dat_byte;

    always #4 clk = ~clk;

    dphy_hs_seq #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_data(tx_data), .tx_ready(tx_ready),
        .cfg_lpx(c_lpx), .cfg_hs_prep(c_hp), .cfg_hs_zero(c_hz), .cfg_hs_trail(c_ht),
        .cfg_hs_exit(c_hx), .cfg_ck_prep(c_cp), .cfg_ck_zero(c_cz), .cfg_ck_post(c_cpo),
        .cfg_ck_trail(c_ct), .cfg_ck_exit(c_cx),
        .dat_state(dat_state), .dat_byte(dat_byte), .clk_state(clk_state)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [2:0] ld [LOGN];
    logic [2:0] lc [LOGN];
    logic [7:0] lb [LOGN];
    logic       lr [LOGN];
    logic [7:0] pay [32];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input logic [CNT_W-1:0] c);
        return (c == '0) ? 1 : int'(c);
    endfunction

    function automatic int run_d(input int from, input logic [2:0] code);
        int n = 0;
        for (int i = from; i < LOGN && ld[i] == code; i++) n++;
        return n;
    endfunction

    function automatic int run_c(input int from, input logic [2:0] code);
        int n = 0;
        for (int i = from; i < LOGN && lc[i] == code; i++) n++;
        return n;
    endfunction

    task automatic set_cfg(input int lpx, hp, hz, ht, hx, cp, cz, cpo, ct, cx);
        c_lpx = lpx[CNT_W-1:0]; c_hp = hp[CNT_W-1:0]; c_hz = hz[CNT_W-1:0];
        c_ht = ht[CNT_W-1:0]; c_hx = hx[CNT_W-1:0]; c_cp = cp[CNT_W-1:0];
        c_cz = cz[CNT_W-1:0]; c_cpo = cpo[CNT_W-1:0]; c_ct = ct[CNT_W-1:0];
        c_cx = cx[CNT_W-1:0];
    endtask

    task automatic do_reset();
        tx_req = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // bytes 0..k-1 form burst A, k..n-1 burst B (raised once data trail is seen)
    task automatic drive(input int n, input int k);
        int  idx = 0;
        bit  seen = 0;
        bit  wacc = 0;
        for (int c = 0; c < LOGN; c++) begin
            @(negedge clk);
            if (wacc) idx++;
            if (idx >= k && dat_state == 3'd5) seen = 1;
            tx_req  = (idx < n) && (idx < k || seen);
            tx_data = pay[(idx < n) ? idx : 0];
            ld[c] = dat_state; lc[c] = clk_state; lb[c] = dat_byte; lr[c] = tx_ready;
            wacc = tx_req && tx_ready;
        end
        tx_req = 1'b0;
    endtask

    // checks one burst from log index s using payload [a,b); returns clock trail end
    task automatic check_burst(input int s, input int a, input int b, output int j);
        int i, ci, len;
        logic [7:0] last;
        ci = s;
        while (ci < LOGN && lc[ci] != 3'd1) ci++;
        chk(ci < LOGN, "R6 clock entry found", ci, 0);
        if (ci >= LOGN) begin j = LOGN; return; end
        len = run_c(ci, 3'd1); chk(len == eff(c_lpx), "R6 clock LP-01", len, eff(c_lpx)); ci += len;
        len = run_c(ci, 3'd2); chk(len == eff(c_cp), "R6 clock LP-00", len, eff(c_cp)); ci += len;
        len = run_c(ci, 3'd3); chk(len == eff(c_cz), "R6 clock HS-0", len, eff(c_cz)); ci += len;
        chk(lc[ci] == 3'd4, "R6 clock running", int'(lc[ci]), 4);
        i = ci;
        while (i < LOGN && ld[i] != 3'd1) i++;
        chk(i < LOGN, "R2 data entry found", i, 0);
        if (i >= LOGN) begin j = LOGN; return; end
        chk(lc[i] == 3'd4, "R7 clock HS at data LP-01", int'(lc[i]), 4);
        len = run_d(i, 3'd1); chk(len == eff(c_lpx), "R2 data LP-01", len, eff(c_lpx)); i += len;
        len = run_d(i, 3'd2); chk(len == eff(c_hp), "R2 data LP-00", len, eff(c_hp)); i += len;
        len = run_d(i, 3'd3); chk(len == eff(c_hz), "R2 data HS-0", len, eff(c_hz)); i += len;
        len = run_d(i, 3'd4); chk(len == b - a + 1, "R3 HS-data length", len, b - a + 1);
        chk(lb[i] == 8'hB8, "R3 sync byte", int'(lb[i]), 8'hB8);
        for (int q = 0; q < b - a; q++)
            chk(lb[i+1+q] == pay[a+q], "R3 payload order", int'(lb[i+1+q]), int'(pay[a+q]));
        i += len;
        last = (b > a) ? pay[b-1] : 8'hB8;
        len = run_d(i, 3'd5); chk(len == eff(c_ht), "R4 trail length", len, eff(c_ht));
        chk(lb[i] == {8{~last[7]}}, "R4 trail byte", int'(lb[i]), int'({8{~last[7]}}));
        i += len;
        len = run_d(i, 3'd0); chk(len >= eff(c_hx), "R5 data exit hold", len, eff(c_hx));
        len = run_c(i, 3'd4); chk(len == eff(c_cpo), "R8 clock post", len, eff(c_cpo));
        j = i + len;
        len = run_c(j, 3'd5); chk(len == eff(c_ct), "R8 clock trail", len, eff(c_ct));
        j += len;
    endtask

    task automatic check_ready_log();
        int bad = 0;
        for (int c = 0; c < LOGN; c++) if (lr[c] && ld[c] != 3'd4) bad++;
        chk(bad == 0, "R3 ready only in HS-data", bad, 0);
    endtask

    task automatic t_reset();
        set_cfg(16, 3, 5, 5, 5, 10, 12, 10, 3, 14);
        do_reset();
        chk(dat_state == 3'd0, "R1 data LP-11", int'(dat_state), 0);
        chk(clk_state == 3'd0, "R1 clock LP-11", int'(clk_state), 0);
        chk(tx_ready == 1'b0, "R1 ready low", int'(tx_ready), 0);
        chk(dat_byte == 8'h00, "R1 byte zero", int'(dat_byte), 0);
    endtask

    task automatic t_default_msb1();
        int j;
        set_cfg(16, 3, 5, 5, 5, 10, 12, 10, 3, 14);
        do_reset();
        pay[0] = 8'h11; pay[1] = 8'hA5; pay[2] = 8'h3C; pay[3] = 8'h9C;
        drive(4, 4);
        check_burst(0, 0, 4, j);
        check_ready_log();
    endtask

    task automatic t_custom_msb0();
        int j;
        set_cfg(2, 4, 7, 3, 2, 5, 6, 4, 2, 3);
        do_reset();
        for (int q = 0; q < 6; q++) pay[q] = 8'(8'hF0 - 8'(q * 17));
        pay[5] = 8'h35;
        drive(6, 6);
        check_burst(0, 0, 6, j);
        check_ready_log();
    endtask

    task automatic t_zero_counts();
        int j;
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_reset();
        pay[0] = 8'h7E;
        drive(1, 1);
        check_burst(0, 0, 1, j); // R9 each phase lasts one cycle
    endtask

    task automatic t_back_to_back();
        int j, len, j2;
        set_cfg(4, 3, 5, 2, 6, 3, 4, 5, 2, 7);
        do_reset();
        pay[0] = 8'h81; pay[1] = 8'h02; pay[2] = 8'hC3;
        pay[3] = 8'h44; pay[4] = 8'h15;
        drive(5, 3);
        check_burst(0, 0, 3, j);
        len = run_c(j, 3'd0);
        chk(len == eff(c_cx) + 1, "R8 clock exit gap", len, eff(c_cx) + 1);
        check_burst(j, 3, 5, j2);
        check_ready_log();
    endtask

    initial begin
        t_reset();
        t_default_msb1();
        t_custom_msb0();
        t_zero_counts();
        t_back_to_back();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule